// File: doc/BRIEF.md
# Card Insertion Detect Interrupt

This block watches the third data line of a memory-card slot and reports when a card is plugged in or pulled out. A removable card pulls that line up while it sits in the slot. The block samples the pad with the system clock, so it works whatever the card bus clock or host controller state is doing. It brings the pad into the clock domain with a short flip-flop chain. It then accepts a new level only after that level has held for a programmable number of cycles.

Each accepted change, insertion or removal, sets a sticky event flag. Software clears the flag by writing a one to it. The interrupt output is the event flag gated by a mask bit. The same pad carries data once the card is being accessed, so software sets the mask during transfers. Data toggling then never shows up as a slot event. A live card-present output gives the current filtered level.

Top module: `card_detect_irq`

## Requirements
- R1: After reset, card_present, event_flag, mask_bit and irq are all 0.
- R2: A pad level that differs from card_present and holds through L+1 consecutive synchronized samples (L = debounce_limit) is accepted. card_present takes the new level on the (L+3)-th rising clock edge after the pad changes, and not earlier.
- R3: A pad excursion shorter than L+1 clock cycles that returns to the accepted level leaves card_present and event_flag unchanged.
- R4: An accepted rise of the pad (insertion) sets event_flag on the same edge where card_present goes to 1.
- R5: An accepted fall of the pad (removal) sets event_flag on the same edge where card_present goes to 0.
- R6: A write with stat_we=1 clears event_flag only when stat_wdata bit 6 is 1. Writing 0 in bit 6 leaves the flag set.
- R7: A write with ctrl_we=1 loads mask_bit from ctrl_wdata bit 6. irq equals event_flag AND NOT mask_bit at all times.
- R8: When an accepted change and a clearing write land on the same edge, event_flag ends up 1.
- R9: With debounce_limit 0, a change is accepted after a single synchronized sample, on the third rising edge after the pad changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat3_pin | input | 1 | Raw level of the data-line-3 pad |
| debounce_limit | input | CNT_W | Extra stable samples required before a change is accepted |
| ctrl_we | input | 1 | Write strobe for the mask register |
| ctrl_wdata | input | REG_W | Mask register write data, mask in bit 6 |
| stat_we | input | 1 | Write strobe for the status register |
| stat_wdata | input | REG_W | Status write data, bit 6 clears the event flag when 1 |
| card_present | output | 1 | Filtered pad level |
| event_flag | output | 1 | Sticky insertion/removal event |
| mask_bit | output | 1 | Current mask value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W=4 and REG_W=8. With this counter width the limits 0 to 6 used by the random stimulus, and the 15 used in a directed case, are all legal values. The random pulse widths are drawn on both sides of L+1, so rejected glitches and barely accepted changes both occur at many limits. Directed cases pin down the exact edge of acceptance for limits 0, 3 and 15. They also cover the clear racing an accepted change on the same edge.

// File: rtl/cd_pkg.sv
package cd_pkg;
    localparam int EVT_BIT = 6;

    typedef struct packed {
        logic mask;
        logic evt;
    } cd_ctrl_t;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o,
    output logic             flip_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;
    logic differ;

    always_comb begin
        st_d   = st_q;
        differ = (sample_i != st_q.lvl);
        flip_o = 1'b0;
        if (!differ) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit_i) begin
            st_d.lvl = sample_i;
            st_d.cnt = '0;
            flip_o   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;

    AST_LEVEL_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> ($past(sample_i) == st_q.lvl)); // R2
    AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i == st_q.lvl) |=> (st_q.cnt == '0)); // R3
endmodule

// File: rtl/card_detect_irq.sv
module card_detect_irq #(
    parameter int CNT_W = 16,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat3_pin,
    input  logic [CNT_W-1:0] debounce_limit,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             stat_we,
    input  logic [REG_W-1:0] stat_wdata,
    output logic             card_present,
    output logic             event_flag,
    output logic             mask_bit,
    output logic             irq
);
    import cd_pkg::*;

    logic pin_sync;
    logic flip;
    cd_ctrl_t ctl_d, ctl_q;

    cd_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(dat3_pin),
        .sync_o (pin_sync)
    );

    cd_debounce #(.CNT_W(CNT_W)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(pin_sync),
        .limit_i (debounce_limit),
        .level_o (card_present),
        .flip_o  (flip)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_we) ctl_d.mask = ctrl_wdata[EVT_BIT];
        if (stat_we && stat_wdata[EVT_BIT]) ctl_d.evt = 1'b0;
        if (flip) ctl_d.evt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign event_flag = ctl_q.evt;
    assign mask_bit   = ctl_q.mask;
    assign irq        = ctl_q.evt & ~ctl_q.mask;

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |-> !irq); // R7
    AST_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(card_present) |-> event_flag); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flag && !(stat_we && stat_wdata[EVT_BIT])) |=> event_flag); // R6
endmodule

// File: tb/card_detect_irq_bench.sv
module card_detect_irq_bench;
    localparam int CNT_W = 4;
    localparam int REG_W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic dat3_pin = 0;
    logic [CNT_W-1:0] debounce_limit = '0;
    logic ctrl_we = 0, stat_we = 0;
    logic [REG_W-1:0] ctrl_wdata = '0, stat_wdata = '0;
    logic card_present, event_flag, mask_bit, irq;
    int total = 0, fails = 0;

    always #2.5 clk = ~clk;

    card_detect_irq #(.CNT_W(CNT_W), .REG_W(REG_W)) u_card_detect_irq (
        .clk(clk), .rst_n(rst_n), .dat3_pin(dat3_pin), .debounce_limit(debounce_limit),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .card_present(card_present), .event_flag(event_flag), .mask_bit(mask_bit), .irq(irq)
    );

    function automatic logic exp_accept(int width, int lim);
        return width > lim;
    endfunction

    function automatic logic exp_irq(logic evt, logic msk);
        return evt & ~msk;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_evt();
        stat_we = 1; stat_wdata = 8'h40;
        @(negedge clk);
        stat_we = 0; stat_wdata = '0;
    endtask

    task automatic set_mask(logic m);
        ctrl_we = 1; ctrl_wdata = {1'b0, m, 6'b0};
        @(negedge clk);
        ctrl_we = 0; ctrl_wdata = '0;
    endtask

    // drive a change and check the exact acceptance edge
    task automatic timed_change(string req, logic lvl, int lim);
        debounce_limit = lim[CNT_W-1:0];
        dat3_pin = lvl;
        wait_n(lim + 2);
        chk(req, card_present, ~lvl);
        wait_n(1);
        chk(req, card_present, lvl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic cur;
        void'($urandom(32'd4242));
        wait_n(3);
        // R1 reset state
        chk("R1 present", card_present, 0);
        chk("R1 event", event_flag, 0);
        chk("R1 mask", mask_bit, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        wait_n(2);

        // R2 / R4 insertion timing with limit 3
        timed_change("R2 rise L3", 1'b1, 3);
        chk("R4 insertion flag", event_flag, 1);
        chk("R7 irq unmasked", irq, exp_irq(1, 0));

        // R6 write with bit6=0 keeps flag, bit6=1 clears
        stat_we = 1; stat_wdata = 8'hBF;
        wait_n(1);
        stat_we = 0;
        chk("R6 no-clear write", event_flag, 1);
        clear_evt();
        chk("R6 w1c", event_flag, 0);

        // R5 removal timing with limit 15
        timed_change("R2 fall L15", 1'b0, 15);
        chk("R5 removal flag", event_flag, 1);

        // R7 mask
        set_mask(1);
        chk("R7 mask loaded", mask_bit, 1);
        chk("R7 irq masked", irq, exp_irq(1, 1));
        set_mask(0);
        chk("R7 irq restored", irq, exp_irq(1, 0));
        clear_evt();

        // R9 limit 0
        timed_change("R9 limit0 rise", 1'b1, 0);

        // R8 clear on the acceptance edge; flag already set beforehand
        debounce_limit = 4'd2;
        dat3_pin = 1'b0;
        wait_n(2 + 2);
        chk("R8 pre-edge flag", event_flag, 1);
        stat_we = 1; stat_wdata = 8'h40;
        wait_n(1);
        stat_we = 0; stat_wdata = '0;
        chk("R8 present changed", card_present, 0);
        chk("R8 set beats clear", event_flag, 1);
        clear_evt();

        // R3 directed glitch just below the threshold
        debounce_limit = 4'd5;
        dat3_pin = 1'b1; wait_n(5); dat3_pin = 1'b0;
        wait_n(20);
        chk("R3 glitch present", card_present, 0);
        chk("R3 glitch event", event_flag, 0);

        // random pulses, R3 / R4 / R5
        for (int it = 0; it < 40; it++) begin
            int lim, w;
            logic acc;
            lim = $urandom_range(0, 6);
            w = $urandom_range(1, lim + 3);
            acc = exp_accept(w, lim);
            cur = card_present;
            debounce_limit = lim[CNT_W-1:0];
            dat3_pin = ~cur; wait_n(w); dat3_pin = cur;
            wait_n(lim + 12);
            chk(acc ? "R4/R5 pulse accepted" : "R3 pulse rejected", event_flag, acc);
            chk("R3 level restored", card_present, cur);
            if (event_flag) clear_evt();
            // R7: irq always tracks flag and mask
            chk("R7 irq relation", irq, exp_irq(event_flag, mask_bit));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule